// File: doc/BRIEF.md
# Guarded In-System Programming Controller

This block is a special-function-register slice for a small 8-bit microcontroller. It holds the in-system programming control byte behind a two-key unlock sequence. It tracks whether the CPU fetches from the 64 KB main bank or from the 4 KB loader bank. It can also pull the CPU into a software reset. Software writes the keys to a dedicated key register. Once access is open, it sets the control byte and puts the CPU into idle. When the CPU next wakes, the block moves execution to the loader bank and clears the program counter.

While code runs from the loader bank, software loads a 16-bit target address, a data byte and a command byte. Each write of the command byte emits a one-cycle strobe to the flash programmer. When the update is finished, one control write with the reset pattern pulses the CPU reset. That reset returns fetching to the main bank and restores the block's protected state.

Top module: `isp_guard`

## Requirements
- R1: After reset the control byte reads 0x00, the loader-bank select is 0 (main bank), and cpu_reset, pc_clear and cmd_valid are all 0.
- R2: While the key register is not open, writes to the control register leave it unchanged.
- R3: A write of 0x87 to the key register followed by a write of 0x59 to the key register, with no other key write between them, opens the control register to writes.
- R4: Any key-register write that does not continue the sequence closes access again. This includes any key write while access is open.
- R5: Key sequences other than exactly 0x87 then 0x59 do not open access. Examples are 0x59 then 0x87, and 0x87, 0x87, 0x59.
- R6: Control bit 0 does not move execution on its own. The loader-bank select rises only on a wake pulse that follows an idle-entry pulse while bit 0 is set. A wake with no prior idle entry has no effect.
- R7: In the cycle the loader-bank select rises, pc_clear is high for exactly one cycle.
- R8: A write to the command register while the loader bank is selected gives cmd_valid for exactly one cycle on the next cycle. The strobe carries address {high, low}, the data byte and the written command byte. In the main bank no strobe is issued.
- R9: A control write with bits 0, 1 and 7 set (mask 0x83) drives cpu_reset high for exactly 4 cycles, starting the cycle after the write. It returns the bank select to main, clears the control byte to 0x00 and closes key access.
- R10: A register read returns its value one cycle after the address is presented. The default addresses are: control 0x9F, key 0xF6, address high 0x84, address low 0x85, data 0x8E, command 0x8F. The key register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_wr_i | input | 1 | Register write enable |
| sfr_wr_addr_i | input | ADDR_W | Write address |
| sfr_wr_data_i | input | 8 | Write data |
| sfr_rd_addr_i | input | ADDR_W | Read address |
| sfr_rd_data_o | output | 8 | Registered read data |
| idle_enter_i | input | 1 | CPU enters idle (pulse) |
| wake_i | input | 1 | CPU wakes from idle (pulse) |
| loader_bank_o | output | 1 | 1 = fetch from loader bank |
| pc_clear_o | output | 1 | Clear program counter (pulse) |
| cpu_reset_o | output | 1 | Software CPU reset |
| cmd_valid_o | output | 1 | Programming command strobe |
| cmd_addr_o | output | 16 | Target flash address |
| cmd_data_o | output | 8 | Programming data byte |
| cmd_code_o | output | 8 | Command byte |

## Verification
The bench builds the block with its defaults: 8-bit register addresses and a 4-cycle software reset. The short reset lets every cycle of the pulse be sampled and the end of the pulse be seen at the ports. The default address map lets the bench reach every register, including reads of the key register and the guarded control byte. The bench covers bad key orderings, closing access after it has opened, wake without idle, and command writes in both banks.

// File: rtl/isp_guard_pkg.sv
package isp_guard_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h87;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h59;
  localparam logic [DATA_W-1:0] SWRST_MASK = 8'h83;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/isp_guard_unlock.sv
module isp_guard_unlock
  import isp_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              open_o
);
  key_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      state_q <= KS_LOCKED;
    end else if (key_wr_i) begin
      if (state_q == KS_LOCKED && data_i == KEY_FIRST)
        state_q <= KS_HALF;
      else if (state_q == KS_HALF && data_i == KEY_SECOND)
        state_q <= KS_OPEN;
      else
        state_q <= KS_LOCKED;
    end
  end

  assign open_o = (state_q == KS_OPEN);

  p_open_needs_key2_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == KS_OPEN && $past(state_q) != KS_OPEN)
      |-> $past(key_wr_i && data_i == KEY_SECOND && state_q == KS_HALF));

  p_key_write_leaves_open_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == KS_OPEN && $past(key_wr_i)) |-> (state_q == KS_LOCKED));
endmodule

// File: rtl/isp_guard_mode.sv
module isp_guard_mode
  import isp_guard_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              open_i,
  input  logic              idle_i,
  input  logic              wake_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              loader_o,
  output logic              pc_clear_o,
  output logic              cpu_rst_o,
  output logic              swrst_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [DATA_W-1:0] ctrl_q;
  logic              loader_q, pcclr_q, in_idle_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              accept, do_switch;

  assign accept    = ctrl_wr_i && open_i;
  assign swrst_o   = accept && ((data_i & SWRST_MASK) == SWRST_MASK);
  assign do_switch = wake_i && in_idle_q && ctrl_q[0] && !loader_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      loader_q  <= 1'b0;
      pcclr_q   <= 1'b0;
      in_idle_q <= 1'b0;
      cnt_q     <= '0;
    end else if (swrst_o) begin
      ctrl_q    <= '0;
      loader_q  <= 1'b0;
      pcclr_q   <= 1'b0;
      in_idle_q <= 1'b0;
      cnt_q     <= CNT_W'(RST_CYCLES);
    end else begin
      if (accept) ctrl_q <= data_i;
      if (wake_i)      in_idle_q <= 1'b0;
      else if (idle_i) in_idle_q <= 1'b1;
      if (do_switch) loader_q <= 1'b1;
      pcclr_q <= do_switch;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign loader_o   = loader_q;
  assign pc_clear_o = pcclr_q;
  assign cpu_rst_o  = (cnt_q != '0);

  p_ctrl_guarded_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_q) |-> $past(ctrl_wr_i && open_i));

  p_switch_on_wake_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(loader_q) |-> $past(wake_i));

  p_pcclr_with_switch_r7: assert property (@(posedge clk) disable iff (rst)
    pcclr_q |-> (loader_q && !$past(loader_q)));

  p_reset_in_main_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_o |-> !loader_q);

  p_reset_from_write_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rst_o) |-> $past(ctrl_wr_i && open_i));
endmodule

// File: rtl/isp_guard_progregs.sv
module isp_guard_progregs
  import isp_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ahi_wr_i,
  input  logic              alo_wr_i,
  input  logic              dat_wr_i,
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              isp_i,
  output logic [DATA_W-1:0] ahi_o,
  output logic [DATA_W-1:0] alo_o,
  output logic [DATA_W-1:0] dat_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cmd_valid_o
);
  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ahi_o   <= '0;
      alo_o   <= '0;
      dat_o   <= '0;
      cmd_o   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (ahi_wr_i) ahi_o <= data_i;
      if (alo_wr_i) alo_o <= data_i;
      if (dat_wr_i) dat_o <= data_i;
      if (cmd_wr_i) cmd_o <= data_i;
      valid_q <= cmd_wr_i && isp_i;
    end
  end

  assign cmd_valid_o = valid_q;

  p_strobe_only_isp_r8: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(isp_i && cmd_wr_i));
endmodule

// File: rtl/isp_guard.sv
module isp_guard
  import isp_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned RST_CYCLES = 4,
  parameter int unsigned A_CTRL     = 'h9F,
  parameter int unsigned A_KEY      = 'hF6,
  parameter int unsigned A_AHI      = 'h84,
  parameter int unsigned A_ALO      = 'h85,
  parameter int unsigned A_DAT      = 'h8E,
  parameter int unsigned A_CMD      = 'h8F
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sfr_wr_i,
  input  logic [ADDR_W-1:0]   sfr_wr_addr_i,
  input  logic [DATA_W-1:0]   sfr_wr_data_i,
  input  logic [ADDR_W-1:0]   sfr_rd_addr_i,
  output logic [DATA_W-1:0]   sfr_rd_data_o,
  input  logic                idle_enter_i,
  input  logic                wake_i,
  output logic                loader_bank_o,
  output logic                pc_clear_o,
  output logic                cpu_reset_o,
  output logic                cmd_valid_o,
  output logic [2*DATA_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0]   cmd_data_o,
  output logic [DATA_W-1:0]   cmd_code_o
);
  localparam logic [ADDR_W-1:0] AC = A_CTRL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] AK = A_KEY[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] AH = A_AHI[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] AL = A_ALO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] AD = A_DAT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] AM = A_CMD[ADDR_W-1:0];

  logic              key_open, swrst;
  logic [DATA_W-1:0] ctrl, ahi, alo, dat, cmd;

  isp_guard_unlock u_unlock (
    .clk(clk), .rst(rst), .clr_i(swrst),
    .key_wr_i(sfr_wr_i && sfr_wr_addr_i == AK),
    .data_i(sfr_wr_data_i), .open_o(key_open)
  );

  isp_guard_mode #(.RST_CYCLES(RST_CYCLES)) u_mode (
    .clk(clk), .rst(rst),
    .ctrl_wr_i(sfr_wr_i && sfr_wr_addr_i == AC),
    .data_i(sfr_wr_data_i), .open_i(key_open),
    .idle_i(idle_enter_i), .wake_i(wake_i),
    .ctrl_o(ctrl), .loader_o(loader_bank_o), .pc_clear_o(pc_clear_o),
    .cpu_rst_o(cpu_reset_o), .swrst_o(swrst)
  );

  isp_guard_progregs u_regs (
    .clk(clk), .rst(rst),
    .ahi_wr_i(sfr_wr_i && sfr_wr_addr_i == AH),
    .alo_wr_i(sfr_wr_i && sfr_wr_addr_i == AL),
    .dat_wr_i(sfr_wr_i && sfr_wr_addr_i == AD),
    .cmd_wr_i(sfr_wr_i && sfr_wr_addr_i == AM),
    .data_i(sfr_wr_data_i), .isp_i(loader_bank_o),
    .ahi_o(ahi), .alo_o(alo), .dat_o(dat), .cmd_o(cmd),
    .cmd_valid_o(cmd_valid_o)
  );

  assign cmd_addr_o = {ahi, alo};
  assign cmd_data_o = dat;
  assign cmd_code_o = cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      sfr_rd_data_o <= '0;
    end else begin
      case (sfr_rd_addr_i)
        AC:      sfr_rd_data_o <= ctrl;
        AH:      sfr_rd_data_o <= ahi;
        AL:      sfr_rd_data_o <= alo;
        AD:      sfr_rd_data_o <= dat;
        AM:      sfr_rd_data_o <= cmd;
        default: sfr_rd_data_o <= '0;
      endcase
    end
  end
endmodule

// File: tb/isp_guard_tb_top.sv
module isp_guard_tb_top;
  localparam logic [7:0] A_CTRL = 8'h9F, A_KEY = 8'hF6, A_AHI = 8'h84,
                         A_ALO = 8'h85, A_DAT = 8'h8E, A_CMD = 8'h8F;

  logic clk = 1'b0, rst = 1'b1;
  logic sfr_wr = 1'b0, idle_en = 1'b0, wake = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
  logic loader, pcclr, cpurst, cvalid;
  logic [15:0] caddr;
  logic [7:0] cdata, ccode;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  isp_guard dut_i (
    .clk(clk), .rst(rst),
    .sfr_wr_i(sfr_wr), .sfr_wr_addr_i(wr_addr), .sfr_wr_data_i(wr_data),
    .sfr_rd_addr_i(rd_addr), .sfr_rd_data_o(rd_data),
    .idle_enter_i(idle_en), .wake_i(wake),
    .loader_bank_o(loader), .pc_clear_o(pcclr), .cpu_reset_o(cpurst),
    .cmd_valid_o(cvalid), .cmd_addr_o(caddr), .cmd_data_o(cdata),
    .cmd_code_o(ccode)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); sfr_wr = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); sfr_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic unlock();
    wr(A_KEY, 8'h87); wr(A_KEY, 8'h59);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_CTRL, v);
    chk("R1 ctrl", v, 8'h00);
    chk("R1 loader", loader, 0); chk("R1 cpu_reset", cpurst, 0);
    chk("R1 pc_clear", pcclr, 0); chk("R1 cmd_valid", cvalid, 0);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    wr(A_CTRL, 8'h41); rd(A_CTRL, v);
    chk("R2 locked write ignored", v, 8'h00);
  endtask

  task automatic t_bad_seq();
    logic [7:0] v;
    wr(A_KEY, 8'h59); wr(A_KEY, 8'h87); wr(A_CTRL, 8'h40); rd(A_CTRL, v);
    chk("R5 reversed keys", v, 8'h00);
    wr(A_KEY, 8'h00); wr(A_KEY, 8'h87); wr(A_KEY, 8'h87); wr(A_KEY, 8'h59);
    wr(A_CTRL, 8'h40); rd(A_CTRL, v);
    chk("R5 doubled first key", v, 8'h00);
    rd(A_KEY, v);
    chk("R10 key reads zero", v, 8'h00);
  endtask

  task automatic t_unlock_close();
    logic [7:0] v;
    wr(A_KEY, 8'h00);
    unlock(); wr(A_CTRL, 8'h40); rd(A_CTRL, v);
    chk("R3 open write taken", v, 8'h40);
    wr(A_KEY, 8'h12); wr(A_CTRL, 8'h00); rd(A_CTRL, v);
    chk("R4 closed by other value", v, 8'h40);
    unlock(); wr(A_KEY, 8'h59); wr(A_CTRL, 8'h00); rd(A_CTRL, v);
    chk("R4 key write while open closes", v, 8'h40);
    unlock(); wr(A_CTRL, 8'h00); rd(A_CTRL, v);
    chk("R3 reopen", v, 8'h00);
  endtask

  task automatic t_main_cmd();
    logic [7:0] v;
    wr(A_AHI, 8'h12); wr(A_ALO, 8'h34); wr(A_DAT, 8'h5A);
    rd(A_AHI, v); chk("R10 addr high", v, 8'h12);
    rd(A_ALO, v); chk("R10 addr low", v, 8'h34);
    rd(A_DAT, v); chk("R10 data", v, 8'h5A);
    wr(A_CMD, 8'h21);
    chk("R8 no strobe in main bank", cvalid, 0);
    rd(A_CMD, v); chk("R10 cmd", v, 8'h21);
  endtask

  task automatic t_isp_switch();
    wr(A_CTRL, 8'h01);
    chk("R6 no immediate switch", loader, 0);
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    chk("R6 wake without idle", loader, 0);
    chk("R7 no pc_clear", pcclr, 0);
    @(negedge clk); idle_en = 1'b1; @(negedge clk); idle_en = 1'b0;
    chk("R6 idle alone", loader, 0);
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    chk("R6 switched on wake", loader, 1);
    chk("R7 pc_clear pulse", pcclr, 1);
    @(negedge clk);
    chk("R7 pc_clear one cycle", pcclr, 0);
  endtask

  task automatic t_isp_cmd();
    wr(A_CMD, 8'h5C);
    chk("R8 strobe", cvalid, 1);
    chk("R8 addr", caddr, 16'h1234);
    chk("R8 data", cdata, 8'h5A);
    chk("R8 code", ccode, 8'h5C);
    @(negedge clk);
    chk("R8 strobe one cycle", cvalid, 0);
  endtask

  task automatic t_swrst();
    logic [7:0] v;
    wr(A_CTRL, 8'h83);
    for (int i = 0; i < 4; i++) begin
      chk("R9 cpu_reset high", cpurst, 1);
      if (i == 0) chk("R9 back to main", loader, 0);
      @(negedge clk);
    end
    chk("R9 cpu_reset ends", cpurst, 0);
    rd(A_CTRL, v); chk("R9 ctrl cleared", v, 8'h00);
    wr(A_CTRL, 8'h40); rd(A_CTRL, v);
    chk("R9 access closed", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_locked();
    t_bad_seq();
    t_unlock_close();
    t_main_cmd();
    t_isp_switch();
    t_isp_cmd();
    t_swrst();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule